// File: doc/BRIEF.md
# Scaled PWM Timer with Register Access

A register-mapped pulse-width modulation timer. One up-counter drives four compare channels. A 4-bit scale in the configuration register picks a 16-bit window of that counter. The window is the value `count >> scale`, and it goes to every comparator. A channel's pin is active-low. The pin is driven low while the scaled count is below the channel's compare value.

The counter runs in one of two ways. A persistent enable keeps it running. A one-shot enable stops it by clearing itself when the counter next restarts. The counter restarts at the natural end of a period, 2^(16+scale) ticks. If zero-on-compare is set, it restarts earlier, once the scaled count reaches the first compare value; that compare value then sets the period. Each channel also keeps a pending flag that follows its match. In sticky mode the flag latches until software clears it.

Software reaches the block through a simple word-wide register bus. A write completes in one cycle. Read data is combinational from the current register state.

Top module: `pwm_timer`

## Requirements
- R1: After reset every register reads zero, every `pwmOutN` pin is high and `irqPend` is zero. Register byte addresses are: configuration 0x00, counter 0x08, scaled count 0x10, and compare channel i at 0x20+4*i. Other addresses read zero. `busRdata` is zero unless `busSel` is high and `busWrite` is low.
- R2: The configuration register fields are: scale in bits 3:0, sticky in bit 8, zero-on-compare in bit 9, persistent run in bit 12, one-shot run in bit 13, and the pending flag of channel i in bit 28+i. All other bits read zero.
- R3: The counter goes up by one per clock while persistent run or one-shot run is set. Otherwise it holds its value. A bus write to 0x08 loads bits 30:0 of the write data, and this load wins over counting and restarting.
- R4: Address 0x10 returns bits scale+15 down to scale of the counter. Writes to 0x10 have no effect.
- R5: With zero-on-compare clear, while the counter is running and its low 16+scale bits are all ones, the counter is zero on the next cycle. A period is therefore 2^(16+scale) clocks.
- R6: With zero-on-compare set, while the counter is running and the scaled count is at or above compare 0, the counter is zero on the next cycle.
- R7: The one-shot run bit clears itself in the cycle after a restart (a wrap or a zero-on-compare reset) of a running counter, unless the configuration register is written in that same cycle.
- R8: `pwmOutN[i]` is low exactly while the current scaled count is below compare i. It follows the current register values with no pipeline delay.
- R9: A compare value of 0 keeps its pin high at all times. A compare value of 0xFFFF still leaves the pin high while the scaled count is 0xFFFF.
- R10: A write to compare i or to the scale field takes effect from the next cycle. There is no shadow copy.
- R11: With sticky clear, `irqPend[i]` on each cycle equals the previous cycle's value of (scaled count >= compare i).
- R12: With sticky set, a pending flag that is set stays set. A configuration write loads all pending flags from bits 28+i of the write data, and this write wins over the match update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| pwmOutN | output | 4 | Active-low PWM pins, one per channel |
| irqPend | output | 4 | Per-channel pending flags |

## Verification
A wrong counter value is visible at once. It shows in the scaled-count and counter reads in the same cycle, and it moves pin edges in that cycle too. A wrong restart or scale decision shows one cycle later, as a counter that fails to return to zero or steps the wrong slice. A wrong one-shot or pending flag shows in the configuration read and on `irqPend` one cycle after the event that should have changed it. The bench therefore compares the pins, the flags and the read data of the addressed register against a behavioural model on every clock, so a miscompare is caught in the cycle it first appears.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  // byte offsets decoded by the register bus
  localparam int OFF_CFG      = 'h00;
  localparam int OFF_CNT      = 'h08;
  localparam int OFF_SCALED   = 'h10;
  localparam int OFF_CMP_BASE = 'h20;
  localparam int CMP_STRIDE   = 4;

  // configuration bit positions
  localparam int SCALE_W      = 4;
  localparam int CFG_STICKY   = 8;
  localparam int CFG_ZEROCMP  = 9;
  localparam int CFG_RUN      = 12;
  localparam int CFG_ONESHOT  = 13;
  localparam int CFG_IP_LSB   = 28;

  // strobes from control to datapath
  typedef struct packed {
    logic       cntWr;
    logic       cmpWr;
    logic [7:0] cmpIdx;
  } ctrl_strobe_t;

endpackage

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan #(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CMP_W-1:0] wdata,
  input  logic [CMP_W-1:0] scaledVal,
  output logic [CMP_W-1:0] cmpQ,
  output logic             match,
  output logic             pinN
);

  logic below;

  always_ff @(posedge clk) begin
    if (!rstN)     cmpQ <= '0;
    else if (wrEn) cmpQ <= wdata;
  end

  assign below = scaledVal < cmpQ;
  assign match = ~below;
  assign pinN  = ~below;

endmodule

// File: rtl/pwm_timer_datapath.sv
module pwm_timer_datapath
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 31,
  parameter int CMP_W  = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrl_strobe_t                  strobe,
  input  logic [CNT_W-1:0]              wdata,
  input  logic [SCALE_W-1:0]            scale,
  input  logic                          zeroCmp,
  input  logic                          runEn,
  output logic [CNT_W-1:0]              countQ,
  output logic [CMP_W-1:0]              scaledVal,
  output logic [NUM_CH-1:0][CMP_W-1:0]  cmpQ,
  output logic [NUM_CH-1:0]             matchVec,
  output logic                          restartEvt,
  output logic [NUM_CH-1:0]             pwmOutN
);

  logic [CNT_W-1:0] shifted;
  logic [CNT_W-1:0] periodMask;
  logic             wrapHit;
  logic             zeroHit;

  assign shifted    = countQ >> scale;
  assign scaledVal  = shifted[CMP_W-1:0];
  assign periodMask = ~({CNT_W{1'b1}} << (CMP_W + int'(scale)));
  assign wrapHit    = (countQ & periodMask) == periodMask;
  assign zeroHit    = zeroCmp & (scaledVal >= cmpQ[0]);
  assign restartEvt = runEn & (wrapHit | zeroHit);

  always_ff @(posedge clk) begin
    if (!rstN)             countQ <= '0;
    else if (strobe.cntWr) countQ <= wdata;
    else if (restartEvt)   countQ <= '0;
    else if (runEn)        countQ <= countQ + CNT_W'(1);
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    pwm_timer_chan #(.CMP_W(CMP_W)) u_chan (
      .clk       (clk),
      .rstN      (rstN),
      .wrEn      (strobe.cmpWr && (strobe.cmpIdx == 8'(i))),
      .wdata     (wdata[CMP_W-1:0]),
      .scaledVal (scaledVal),
      .cmpQ      (cmpQ[i]),
      .match     (matchVec[i]),
      .pinN      (pwmOutN[i])
    );
  end

endmodule

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 31,
  parameter int CMP_W  = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busSel,
  input  logic                          busWrite,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [31:0]                   busWdata,
  output logic [31:0]                   busRdata,
  input  logic [CNT_W-1:0]              countQ,
  input  logic [CMP_W-1:0]              scaledVal,
  input  logic [NUM_CH-1:0][CMP_W-1:0]  cmpQ,
  input  logic [NUM_CH-1:0]             matchVec,
  input  logic                          restartEvt,
  output ctrl_strobe_t                  strobe,
  output logic [SCALE_W-1:0]            scaleQ,
  output logic                          stickyQ,
  output logic                          zeroCmpQ,
  output logic                          runQ,
  output logic                          oneShotQ,
  output logic                          runEn,
  output logic [NUM_CH-1:0]             ipQ
);

  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_CNT    = ADDR_W'(OFF_CNT);
  localparam logic [ADDR_W-1:0] A_SCALED = ADDR_W'(OFF_SCALED);
  localparam logic [ADDR_W-1:0] A_CMP    = ADDR_W'(OFF_CMP_BASE);
  localparam logic [ADDR_W-1:0] CMP_SPAN = ADDR_W'(NUM_CH * CMP_STRIDE);

  logic              wrEn, rdEn;
  logic              cfgHit, cntHit, scaledHit, cmpHit;
  logic [ADDR_W-1:0] cmpOff;
  logic [7:0]        cmpIdx;
  logic              unusedWdata;

  assign wrEn      = busSel & busWrite;
  assign rdEn      = busSel & ~busWrite;
  assign cfgHit    = busAddr == A_CFG;
  assign cntHit    = busAddr == A_CNT;
  assign scaledHit = busAddr == A_SCALED;
  assign cmpOff    = busAddr - A_CMP;
  assign cmpHit    = (busAddr >= A_CMP) && (cmpOff < CMP_SPAN) && (cmpOff[1:0] == 2'b00);
  assign cmpIdx    = 8'(cmpOff >> 2);
  assign unusedWdata = ^busWdata;

  always_comb begin
    strobe.cntWr  = wrEn & cntHit;
    strobe.cmpWr  = wrEn & cmpHit;
    strobe.cmpIdx = cmpIdx;
  end

  assign runEn = runQ | oneShotQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scaleQ   <= '0;
      stickyQ  <= 1'b0;
      zeroCmpQ <= 1'b0;
      runQ     <= 1'b0;
      oneShotQ <= 1'b0;
      ipQ      <= '0;
    end else if (wrEn && cfgHit) begin
      scaleQ   <= busWdata[SCALE_W-1:0];
      stickyQ  <= busWdata[CFG_STICKY];
      zeroCmpQ <= busWdata[CFG_ZEROCMP];
      runQ     <= busWdata[CFG_RUN];
      oneShotQ <= busWdata[CFG_ONESHOT];
      ipQ      <= busWdata[CFG_IP_LSB +: NUM_CH];
    end else begin
      if (restartEvt) oneShotQ <= 1'b0;
      ipQ <= stickyQ ? (ipQ | matchVec) : matchVec;
    end
  end

  always_comb begin
    busRdata = '0;
    if (rdEn) begin
      if (cfgHit) begin
        busRdata[SCALE_W-1:0]          = scaleQ;
        busRdata[CFG_STICKY]           = stickyQ;
        busRdata[CFG_ZEROCMP]          = zeroCmpQ;
        busRdata[CFG_RUN]              = runQ;
        busRdata[CFG_ONESHOT]          = oneShotQ;
        busRdata[CFG_IP_LSB +: NUM_CH] = ipQ;
      end else if (cntHit) begin
        busRdata = 32'(countQ);
      end else if (scaledHit) begin
        busRdata = 32'(scaledVal);
      end else begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (cmpHit && (cmpIdx == 8'(i))) busRdata = 32'(cmpQ[i]);
        end
      end
    end
  end

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 31,
  parameter int CMP_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [NUM_CH-1:0] pwmOutN,
  output logic [NUM_CH-1:0] irqPend
);

  ctrl_strobe_t                 strobe;
  logic [SCALE_W-1:0]           scaleQ;
  logic                         stickyQ, zeroCmpQ, runQ, oneShotQ, runEn;
  logic [NUM_CH-1:0]            ipQ;
  logic [CNT_W-1:0]             countQ;
  logic [CMP_W-1:0]             scaledVal;
  logic [NUM_CH-1:0][CMP_W-1:0] cmpQ;
  logic [NUM_CH-1:0]            matchVec;
  logic                         restartEvt;

  pwm_timer_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CMP_W(CMP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .countQ(countQ), .scaledVal(scaledVal),
    .cmpQ(cmpQ), .matchVec(matchVec), .restartEvt(restartEvt), .strobe(strobe),
    .scaleQ(scaleQ), .stickyQ(stickyQ), .zeroCmpQ(zeroCmpQ), .runQ(runQ),
    .oneShotQ(oneShotQ), .runEn(runEn), .ipQ(ipQ)
  );

  pwm_timer_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CMP_W(CMP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(busWdata[CNT_W-1:0]),
    .scale(scaleQ), .zeroCmp(zeroCmpQ), .runEn(runEn), .countQ(countQ),
    .scaledVal(scaledVal), .cmpQ(cmpQ), .matchVec(matchVec),
    .restartEvt(restartEvt), .pwmOutN(pwmOutN)
  );

  assign irqPend = ipQ;

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 31,
  parameter int CMP_W  = 16
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         busSel,
  input logic                         busWrite,
  input logic [ADDR_W-1:0]            busAddr,
  input logic [NUM_CH-1:0]            pwmOutN,
  input logic [NUM_CH-1:0]            irqPend,
  input logic [CNT_W-1:0]             countQ,
  input logic [CMP_W-1:0]             scaledVal,
  input logic [NUM_CH-1:0][CMP_W-1:0] cmpQ,
  input logic                         runEn,
  input logic                         stickyQ,
  input logic                         oneShotQ,
  input logic                         cntWr,
  input logic                         restartEvt
);

  logic cfgWrite;
  assign cfgWrite = busSel && busWrite && (busAddr == '0);

  // R3: idle counter holds
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !cntWr) |=> (countQ == $past(countQ)));

  // R3: running counter steps by one
  assert_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !cntWr && !restartEvt) |=> (countQ == $past(countQ) + CNT_W'(1)));

  // R5 / R6: restart lands on zero
  assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (restartEvt && !cntWr) |=> (countQ == '0));

  // R7: one-shot clears after a restart
  assert_oneshot_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (restartEvt && !cfgWrite) |=> !oneShotQ);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // R9: zero compare never asserts
    assert_cmp_zero_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
      (cmpQ[i] == '0) |-> pwmOutN[i]);
    // R9: full-scale compare leaves one deasserted step
    assert_never_full_R9: assert property (@(posedge clk) disable iff (!rstN)
      ((cmpQ[i] == '1) && (scaledVal == '1)) |-> pwmOutN[i]);
    // R12: sticky flag holds until a configuration write
    assert_sticky_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
      (stickyQ && irqPend[i] && !cfgWrite) |=> irqPend[i]);
  end

endmodule

bind pwm_timer pwm_timer_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CMP_W(CMP_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
  .pwmOutN(pwmOutN), .irqPend(irqPend), .countQ(countQ), .scaledVal(scaledVal),
  .cmpQ(cmpQ), .runEn(runEn), .stickyQ(stickyQ), .oneShotQ(oneShotQ),
  .cntWr(strobe.cntWr), .restartEvt(restartEvt)
);

// File: tb/tb_pwm_timer.sv
`timescale 1ns/100ps
module tb_pwm_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  pwmOutN;
  logic [3:0]  irqPend;

  int vectors = 0;
  int fails = 0;
  string phase = "R1";

  // behavioural model state
  longint mCount;
  int     mScale;
  bit     mSticky, mZero, mRun, mOnce;
  bit [3:0] mIp;
  int     mCmp[4];

  always #2.5 clk = ~clk;

  pwm_timer dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pwmOutN(pwmOutN), .irqPend(irqPend)
  );

  function automatic int mScaled();
    return int'((mCount >> mScale) & 64'hFFFF);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = 0; mScale = 0; mSticky = 0; mZero = 0; mRun = 0; mOnce = 0; mIp = 0;
      foreach (mCmp[k]) mCmp[k] = 0;
    end else begin
      longint mask, nCount;
      int sc;
      bit go, wrap, zer, restart, wr;
      bit [3:0] m;
      mask = (64'd1 << (16 + mScale)) - 1;
      sc = mScaled();
      go = mRun || mOnce;
      wrap = (mCount & mask) == mask;
      zer = mZero && (sc >= mCmp[0]);
      restart = go && (wrap || zer);
      for (int k = 0; k < 4; k++) m[k] = (sc >= mCmp[k]);
      wr = busSel && busWrite;
      nCount = mCount;
      if (wr && busAddr == 8'h08) nCount = longint'(busWdata) & 64'h7FFF_FFFF;
      else if (restart) nCount = 0;
      else if (go) nCount = mCount + 1;
      if (wr && busAddr == 8'h00) begin
        mScale = int'(busWdata[3:0]); mSticky = busWdata[8]; mZero = busWdata[9];
        mRun = busWdata[12]; mOnce = busWdata[13]; mIp = busWdata[31:28];
      end else begin
        if (restart) mOnce = 0;
        mIp = mSticky ? (mIp | m) : m;
      end
      for (int k = 0; k < 4; k++)
        if (wr && busAddr == 8'(8'h20 + 4 * k)) mCmp[k] = int'(busWdata[15:0]);
      mCount = nCount;
    end
  end

  function automatic logic [31:0] expRdata();
    logic [31:0] r = '0;
    if (busSel && !busWrite) begin
      if (busAddr == 8'h00) begin
        r[3:0] = 4'(mScale); r[8] = mSticky; r[9] = mZero;
        r[12] = mRun; r[13] = mOnce; r[31:28] = mIp;
      end else if (busAddr == 8'h08) r = 32'(mCount);
      else if (busAddr == 8'h10) r = 32'(mScaled());
      else for (int k = 0; k < 4; k++) if (busAddr == 8'(8'h20 + 4 * k)) r = 32'(mCmp[k]);
    end
    return r;
  endfunction

  task automatic compareNow();
    logic [3:0] ePin;
    logic [31:0] eRd;
    for (int k = 0; k < 4; k++) ePin[k] = !(mScaled() < mCmp[k]);
    eRd = expRdata();
    vectors++;
    if (pwmOutN !== ePin) begin
      fails++; $display("FAIL %s pins: got %b expected %b", phase, pwmOutN, ePin);
    end
    if (irqPend !== mIp) begin
      fails++; $display("FAIL %s irqPend: got %b expected %b", phase, irqPend, mIp);
    end
    if (busRdata !== eRd) begin
      fails++; $display("FAIL %s rdata @%h: got %h expected %h", phase, busAddr, busRdata, eRd);
    end
  endtask

  task automatic cyc(input logic s, input logic w, input logic [7:0] a, input logic [31:0] d);
    busSel = s; busWrite = w; busAddr = a; busWdata = d;
    #1;
    compareNow();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b1, a, d);
  endtask

  task automatic rdN(input logic [7:0] a, input int n);
    for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, a, 32'h0);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    @(negedge clk);
    phase = "R1";
    cyc(1'b0, 1'b0, 8'h00, 32'h0);
    cyc(1'b0, 1'b0, 8'h00, 32'h0);
    rstN = 1'b1;
    rdN(8'h00, 1); rdN(8'h08, 1); rdN(8'h10, 1);
    rdN(8'h20, 1); rdN(8'h24, 1); rdN(8'h28, 1); rdN(8'h2C, 1);
    rdN(8'h04, 1); rdN(8'h30, 1);
    cyc(1'b1, 1'b1, 8'h00, 32'h0);                  // write data never appears on read

    phase = "R2";
    wr(8'h00, 32'hFFFF_FFFF);
    rdN(8'h00, 3);
    wr(8'h00, 32'h0);
    rdN(8'h00, 2);

    phase = "R10";
    wr(8'h20, 32'd100); wr(8'h24, 32'd0); wr(8'h28, 32'hFFFF); wr(8'h2C, 32'd40);
    rdN(8'h20, 1); rdN(8'h24, 1); rdN(8'h28, 1); rdN(8'h2C, 1);
    wr(8'h08, 32'h0);

    phase = "R8 R11";
    wr(8'h00, 32'h0000_1000);
    rdN(8'h10, 120);

    phase = "R4";
    wr(8'h10, 32'h0000_1234);
    rdN(8'h10, 3);

    phase = "R5 R9";
    wr(8'h08, 32'h0000_FFF8);
    rdN(8'h10, 20);

    phase = "R4 scale";
    wr(8'h00, 32'h0000_1002);
    wr(8'h08, 32'h0003_FFF4);
    rdN(8'h08, 30);
    rdN(8'h10, 10);

    phase = "R6";
    wr(8'h20, 32'd20);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h0000_1200);
    rdN(8'h08, 60);

    phase = "R7";
    wr(8'h20, 32'd10);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h0000_2200);
    rdN(8'h08, 25);
    rdN(8'h00, 5);

    phase = "R12";
    wr(8'h2C, 32'd40);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h0000_1100);
    rdN(8'h00, 60);
    wr(8'h00, 32'h0000_1100);
    rdN(8'h00, 5);
    wr(8'h00, 32'h5000_0100);
    rdN(8'h00, 5);

    phase = "R3";
    wr(8'h00, 32'h0);
    rdN(8'h08, 10);
    wr(8'h08, 32'hFFFF_FFFF);
    rdN(8'h08, 3);

    phase = "R6 scale";
    wr(8'h08, 32'h0);
    wr(8'h20, 32'd5);
    wr(8'h00, 32'h0000_1201);
    rdN(8'h10, 40);

    finishRun();
  end

endmodule